// File: doc/BRIEF.md
# Quadriphase Pulse Compression Correlator

This block sits behind a pair of 10-bit converters that deliver in-phase and quadrature baseband samples. While an active-low acquisition window is open, every sample strobe stores one complex sample into a local buffer. The number of samples kept is the selected reference length plus 16. When the window closes with a full buffer, a sequential engine correlates the stored samples against the selected quadriphase reference. It produces 16 complex range-bin sums, one per lag.

Every reference symbol is a unit phasor (+1, +j, −1, −j), so each term needs only a swap and a negation of the sample, not a multiplier. The engine spends one clock per term, which is 16 × L cycles per interval. A code choice written at any time is held as pending. It becomes active only when the next window opens, so the code never changes while samples are being collected or bins are being computed. The results stay in a 16-entry store that is read by bin index. A single-cycle `done` pulse marks that all 16 bins are fresh.

Top module: `pqc_correlator`

## Requirements
- R1: Each 10-bit converter word is stored as a 16-bit signed value by replicating its bit 9 into bits 10 to 15. I is the real part and Q is the imaginary part.
- R2: A sample is stored only in a cycle where `win_n` is low and `smp_stb` is high. Stored samples are kept in arrival order, and only the first L+16 samples of a window are kept. Strobes outside the window and samples beyond L+16 have no effect on the results.
- R3: The code select values map to reference lengths L as 1→1, 2→3, 3→5, 4→7, 5→11, 6→13, 7→15, 8→21 and 9→31. The symbol sequences, tap 0 first, are:
  - select 1: 0
  - select 2: 002
  - select 3: 00020
  - select 4: 0002202
  - select 5: 00022202202
  - select 6: 0000022002020
  - selects 7 to 9: symbol j equals (j·(j+1)/2) mod 4.
- R4: Bin k, for k = 0 to 15, equals the sum over j = 0 to L−1 of sample[j+k] times the phasor of symbol j. The phasors are symbol 0 → +1, symbol 1 → +j, symbol 2 → −1 and symbol 3 → −j. The real part is cRe·sRe − cIm·sIm, the imaginary part is cRe·sIm + cIm·sRe, and both are 32-bit signed.
- R5: A select written with `sel_we` becomes the active code when the next accepted window opens. A write made while a window is open does not change the code that window uses.
- R6: A select write of 0 or of a value above 9 is ignored, and the previous choice stays in force.
- R7: `done` is high for exactly one cycle after all 16 bins of an interval have been written. Reading the store through `rd_bin` then returns the new results, and they are held unchanged until the next computation.
- R8: A window that closes with fewer than L+16 samples starts no computation and raises no `done`. The stored results stay as they were.
- R9: A window that opens while the engine is still computing is ignored entirely. It produces no `done` and does not alter the results being formed.
- R10: After reset, `done` is low, all 16 stored results read as zero, and select 1 is the active code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| win_n | input | 1 | Acquisition window, active low |
| smp_stb | input | 1 | Sample strobe, one per converter sample |
| adc_i | input | 10 | In-phase converter word, two's complement |
| adc_q | input | 10 | Quadrature converter word, two's complement |
| sel_in | input | 4 | Reference code select, legal values 1 to 9 |
| sel_we | input | 1 | Write strobe for `sel_in` |
| rd_bin | input | 4 | Range bin index to read |
| rd_re | output | 32 | Real part of the selected bin |
| rd_im | output | 32 | Imaginary part of the selected bin |
| done | output | 1 | One-cycle pulse when all 16 bins are fresh |

## Verification
Every code select is exercised, and the bench models the correlation on its own from the symbol table and phasor rule.

Each stimulus pattern targets a different possible error:
- A single impulse places one scaled, rotated copy of the code in the bins. This exposes a wrong tap order, a wrong lag offset or a wrong phasor per symbol.
- Constant full-scale negative and positive words test sign extension and accumulator width.
- Alternating extremes and a hashed sequence mix all four rotations. A swapped real/imaginary path or a wrong sign cannot cancel out under them.

Directed windows then cover:
- stray strobes and surplus samples;
- a window one sample short;
- a window opened during a long computation;
- illegal and mid-window code writes.

// File: rtl/pqc_pkg.sv
`timescale 1ns/1ps
// Shared constants, types and code-table functions for the correlator.
// Assumes at most 31 taps and 16 range bins; all widths derive from these.
package pqc_pkg;

    localparam int ADC_W    = 10;
    localparam int SMP_W    = 16;
    localparam int ACC_W    = 32;
    localparam int N_BINS   = 16;
    localparam int MAX_CODE = 31;
    localparam int N_CODES  = 9;
    localparam int SEL_W    = 4;
    localparam int MAX_SAMP = MAX_CODE + N_BINS;
    localparam int ADDR_W   = $clog2(MAX_SAMP);
    localparam int LEN_W    = ADDR_W;
    localparam int BIN_W    = $clog2(N_BINS);
    localparam int TAP_W    = $clog2(MAX_CODE);

    typedef logic signed [SMP_W-1:0] smp_t;
    typedef logic signed [ACC_W-1:0] acc_t;
    typedef struct packed {
        acc_t re;
        acc_t im;
    } cplx_t;

    // Reference length for a select value; illegal values map to length 1.
    function automatic logic [LEN_W-1:0] code_len(input logic [SEL_W-1:0] sel);
        case (sel)
            SEL_W'(2): return LEN_W'(3);
            SEL_W'(3): return LEN_W'(5);
            SEL_W'(4): return LEN_W'(7);
            SEL_W'(5): return LEN_W'(11);
            SEL_W'(6): return LEN_W'(13);
            SEL_W'(7): return LEN_W'(15);
            SEL_W'(8): return LEN_W'(21);
            SEL_W'(9): return LEN_W'(31);
            default:   return LEN_W'(1);
        endcase
    endfunction

    // Quadriphase symbol at tap j: binary sign codes for short selects,
    // quadratic-phase sequence for the long ones.
    function automatic logic [1:0] code_sym(input logic [SEL_W-1:0] sel,
                                            input logic [TAP_W-1:0] j);
        logic [9:0]          jj;
        logic [9:0]          tri_v;
        logic [MAX_CODE-1:0] neg;
        jj    = 10'(j);
        tri_v = (jj * (jj + 10'd1)) >> 1;
        case (sel)
            SEL_W'(2): neg = 31'b100;
            SEL_W'(3): neg = 31'b01000;
            SEL_W'(4): neg = 31'b1011000;
            SEL_W'(5): neg = 31'b10110111000;
            SEL_W'(6): neg = 31'b0101001100000;
            default:   neg = '0;
        endcase
        if (sel >= SEL_W'(7)) return tri_v[1:0];
        return {neg[j], 1'b0};
    endfunction

    // Multiply a complex value by the unit phasor of a symbol (swap/negate).
    function automatic cplx_t rotate(input logic [1:0] s, input acc_t re, input acc_t im);
        cplx_t r;
        case (s)
            2'd0:    begin r.re = re;  r.im = im;  end
            2'd1:    begin r.re = -im; r.im = re;  end
            2'd2:    begin r.re = -re; r.im = -im; end
            default: begin r.re = im;  r.im = -re; end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pqc_code_sel.sv
`timescale 1ns/1ps
// Holds the pending code choice and the active code used by the current interval.
// Assumes latch pulses only when a window is accepted, so the active code
// never changes during capture or computation.
module pqc_code_sel
    import pqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_in,
    input  logic             sel_we,
    input  logic             latch,
    output logic [SEL_W-1:0] active_sel,
    output logic [LEN_W-1:0] active_len
);

    logic [SEL_W-1:0] pend_q;
    logic [SEL_W-1:0] act_q;
    logic             legal;

    // Accept only select values inside the code table.
    always_comb begin
        legal = (sel_in >= SEL_W'(1)) && (sel_in <= SEL_W'(N_CODES));
    end

    // Pending choice follows legal writes; the active one loads at window start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= SEL_W'(1);
            act_q  <= SEL_W'(1);
        end else begin
            if (sel_we && legal) pend_q <= sel_in;
            if (latch)           act_q  <= pend_q;
        end
    end

    assign active_sel = act_q;
    assign active_len = code_len(act_q);

    // R6: the active code is always one of the nine table entries.
    p_active_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active_sel >= SEL_W'(1)) && (active_sel <= SEL_W'(N_CODES)));

endmodule

// File: rtl/pqc_capture.sv
`timescale 1ns/1ps
// Window tracking and sample buffer. Stores sign-extended complex samples while
// the active-low window is open, up to 'need' entries, and signals 'go' when a
// window closes with a full buffer. Assumes windows are rejected while the
// engine is busy, so the buffer is never written during a computation.
module pqc_capture
    import pqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_n,
    input  logic              smp_stb,
    input  logic [ADC_W-1:0]  adc_i,
    input  logic [ADC_W-1:0]  adc_q,
    input  logic [LEN_W-1:0]  need,
    input  logic              eng_busy,
    input  logic [ADDR_W-1:0] rd_addr,
    output smp_t              rd_re,
    output smp_t              rd_im,
    output logic              win_start,
    output logic              go
);

    logic              win_prev;
    logic              in_win;
    logic [LEN_W-1:0]  count;
    logic              wr;
    logic [ADDR_W-1:0] wr_addr;
    smp_t              smp_re_q [MAX_SAMP];
    smp_t              smp_im_q [MAX_SAMP];

    // Decode window opening, sample writes and the end-of-window hand-off.
    always_comb begin
        win_start = win_prev & ~win_n & ~eng_busy;
        wr        = ~win_n & smp_stb & (win_start | (in_win & (count < need)));
        wr_addr   = win_start ? '0 : ADDR_W'(count);
        go        = in_win & win_n & (count == need);
    end

    // Track the window level, the accepted window and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_prev <= 1'b1;
            in_win   <= 1'b0;
            count    <= '0;
        end else begin
            win_prev <= win_n;
            if (win_start) begin
                in_win <= 1'b1;
                count  <= wr ? LEN_W'(1) : '0;
            end else if (in_win && win_n) begin
                in_win <= 1'b0;
            end else if (wr) begin
                count <= count + LEN_W'(1);
            end
        end
    end

    // Sample storage; contents need no reset since reads follow a full fill.
    always_ff @(posedge clk) begin
        if (wr) begin
            smp_re_q[wr_addr] <= {{(SMP_W-ADC_W){adc_i[ADC_W-1]}}, adc_i};
            smp_im_q[wr_addr] <= {{(SMP_W-ADC_W){adc_q[ADC_W-1]}}, adc_q};
        end
    end

    assign rd_re = smp_re_q[rd_addr];
    assign rd_im = smp_im_q[rd_addr];

    // R2: an accepted window never holds more than the required sample count.
    p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_win |-> (count <= need));

endmodule

// File: rtl/pqc_mac.sv
`timescale 1ns/1ps
// Sequential correlation engine: one rotate-and-add term per cycle, L cycles
// per bin, 16 bins per interval. Writes each finished bin and pulses done
// after the last. Assumes sel and len stay constant while busy.
module pqc_mac
    import pqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [SEL_W-1:0]  sel,
    input  logic [LEN_W-1:0]  len,
    output logic [ADDR_W-1:0] rd_addr,
    input  smp_t              rd_re,
    input  smp_t              rd_im,
    output logic              busy,
    output logic              wr_en,
    output logic [BIN_W-1:0]  wr_bin,
    output cplx_t             wr_val,
    output logic              done
);

    logic [BIN_W-1:0] k;
    logic [TAP_W-1:0] j;
    acc_t             acc_re;
    acc_t             acc_im;
    logic [1:0]       sym;
    cplx_t            term;
    logic             last_tap;
    logic             last_bin;

    // Form the current term and the bin-completion write.
    always_comb begin
        rd_addr   = ADDR_W'(k) + ADDR_W'(j);
        sym       = code_sym(sel, j);
        term      = rotate(sym, acc_t'(rd_re), acc_t'(rd_im));
        last_tap  = (LEN_W'(j) == (len - LEN_W'(1)));
        last_bin  = (k == BIN_W'(N_BINS - 1));
        wr_en     = busy & last_tap;
        wr_bin    = k;
        wr_val.re = acc_re + term.re;
        wr_val.im = acc_im + term.im;
    end

    // Step through taps and bins, accumulating and clearing per bin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            k      <= '0;
            j      <= '0;
            acc_re <= '0;
            acc_im <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (go) begin
                    busy   <= 1'b1;
                    k      <= '0;
                    j      <= '0;
                    acc_re <= '0;
                    acc_im <= '0;
                end
            end else if (last_tap) begin
                acc_re <= '0;
                acc_im <= '0;
                j      <= '0;
                if (last_bin) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    k <= k + BIN_W'(1);
                end
            end else begin
                acc_re <= term.re + acc_re;
                acc_im <= term.im + acc_im;
                j      <= j + TAP_W'(1);
            end
        end
    end

    // R7: done never lasts more than one cycle.
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: done follows directly on the write of the final bin.
    p_done_last_bin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(wr_en) && ($past(wr_bin) == BIN_W'(N_BINS - 1))));

    // R9: a start request from the capture side only arrives when idle.
    p_go_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy);

endmodule

// File: rtl/pqc_results.sv
`timescale 1ns/1ps
// Result store: 16 complex bins, written by the engine, read by bin index.
// Assumes at most one write per cycle; cleared to zero by reset.
module pqc_results
    import pqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BIN_W-1:0] wr_bin,
    input  cplx_t            wr_val,
    input  logic [BIN_W-1:0] rd_bin,
    output cplx_t            rd_val
);

    cplx_t bins_q [N_BINS];

    // Clear on reset, otherwise capture each finished bin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < N_BINS; b++) bins_q[b] <= '0;
        end else if (wr_en) begin
            bins_q[wr_bin] <= wr_val;
        end
    end

    assign rd_val = bins_q[rd_bin];

endmodule

// File: rtl/pqc_correlator.sv
`timescale 1ns/1ps
// Top of the quadriphase pulse compression correlator: code selection,
// windowed sample capture, sequential correlation and result storage.
// Assumes the window gap exceeds 16*L clocks for back-to-back intervals.
module pqc_correlator
    import pqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_n,
    input  logic              smp_stb,
    input  logic [ADC_W-1:0]  adc_i,
    input  logic [ADC_W-1:0]  adc_q,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic              sel_we,
    input  logic [BIN_W-1:0]  rd_bin,
    output logic [ACC_W-1:0]  rd_re,
    output logic [ACC_W-1:0]  rd_im,
    output logic              done
);

    logic [SEL_W-1:0]  active_sel;
    logic [LEN_W-1:0]  active_len;
    logic [LEN_W-1:0]  need;
    logic              win_start;
    logic              go;
    logic              busy;
    logic [ADDR_W-1:0] smp_addr;
    smp_t              smp_re;
    smp_t              smp_im;
    logic              wr_en;
    logic [BIN_W-1:0]  wr_bin;
    cplx_t             wr_val;
    cplx_t             rd_val;

    assign need = active_len + LEN_W'(N_BINS);

    pqc_code_sel u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_in     (sel_in),
        .sel_we     (sel_we),
        .latch      (win_start),
        .active_sel (active_sel),
        .active_len (active_len)
    );

    pqc_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_n     (win_n),
        .smp_stb   (smp_stb),
        .adc_i     (adc_i),
        .adc_q     (adc_q),
        .need      (need),
        .eng_busy  (busy),
        .rd_addr   (smp_addr),
        .rd_re     (smp_re),
        .rd_im     (smp_im),
        .win_start (win_start),
        .go        (go)
    );

    pqc_mac u_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .sel     (active_sel),
        .len     (active_len),
        .rd_addr (smp_addr),
        .rd_re   (smp_re),
        .rd_im   (smp_im),
        .busy    (busy),
        .wr_en   (wr_en),
        .wr_bin  (wr_bin),
        .wr_val  (wr_val),
        .done    (done)
    );

    pqc_results u_res (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_bin (wr_bin),
        .wr_val (wr_val),
        .rd_bin (rd_bin),
        .rd_val (rd_val)
    );

    assign rd_re = rd_val.re;
    assign rd_im = rd_val.im;

    // R5: the code in use cannot change while a computation runs.
    p_code_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(active_sel));

endmodule

// File: tb/pqc_correlator_tb.sv
`timescale 1ns/1ps
module pqc_correlator_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        win_n = 1'b1;
    logic        smp_stb = 1'b0;
    logic [9:0]  adc_i = '0;
    logic [9:0]  adc_q = '0;
    logic [3:0]  sel_in = 4'd1;
    logic        sel_we = 1'b0;
    logic [3:0]  rd_bin = '0;
    logic [31:0] rd_re;
    logic [31:0] rd_im;
    logic        done;

    int n_total = 0;
    int n_pass  = 0;
    int exp_re [16];
    int exp_im [16];

    always #2 clk = ~clk;

    pqc_correlator dut_i (
        .clk(clk), .rst_n(rst_n), .win_n(win_n), .smp_stb(smp_stb),
        .adc_i(adc_i), .adc_q(adc_q), .sel_in(sel_in), .sel_we(sel_we),
        .rd_bin(rd_bin), .rd_re(rd_re), .rd_im(rd_im), .done(done)
    );

    // Stimulus table: {select[3:0], pattern[1:0], seed[5:0]}
    localparam logic [11:0] VEC [11] = '{
        {4'd1, 2'd0, 6'd3},  {4'd2, 2'd2, 6'd1},  {4'd3, 2'd1, 6'd0},
        {4'd4, 2'd2, 6'd7},  {4'd5, 2'd3, 6'd0},  {4'd6, 2'd2, 6'd9},
        {4'd7, 2'd0, 6'd20}, {4'd8, 2'd2, 6'd4},  {4'd9, 2'd2, 6'd11},
        {4'd9, 2'd1, 6'd0},  {4'd6, 2'd0, 6'd28}
    };

    function automatic int blen(input int sel);
        case (sel)
            2: return 3;   3: return 5;   4: return 7;   5: return 11;
            6: return 13;  7: return 15;  8: return 21;  9: return 31;
            default: return 1;
        endcase
    endfunction

    // R3 symbol table, written from the requirement.
    function automatic int bsym(input int sel, input int j);
        string s;
        if (sel >= 7) return ((j * (j + 1)) / 2) % 4;
        case (sel)
            2: s = "002";
            3: s = "00020";
            4: s = "0002202";
            5: s = "00022202202";
            6: s = "0000022002020";
            default: s = "0";
        endcase
        return int'(s[j]) - 48;
    endfunction

    function automatic logic [9:0] gen(input int pat, input int seed, input int n, input int q);
        case (pat)
            0: return (n == seed) ? (q != 0 ? 10'h300 : 10'h1FF) : 10'h000;
            1: return (q != 0) ? 10'h1FF : 10'h200;
            2: return (q != 0) ? 10'(n * n * 7 + seed * 13 + 3) : 10'(n * 73 + seed * 29 + 5);
            default: return (q != 0) ? ((n % 3 == 0) ? 10'h3FF : 10'h155)
                                     : ((n % 2 == 1) ? 10'h200 : 10'h1FF);
        endcase
    endfunction

    // R1 sign extension and R4 correlation model.
    task automatic compute_expected(input int sel, input int pat, input int seed);
        int len;
        len = blen(sel);
        for (int k = 0; k < 16; k++) begin
            int sr, si;
            sr = 0; si = 0;
            for (int j = 0; j < len; j++) begin
                int vr, vi, cr, ci, s;
                vr = int'($signed(gen(pat, seed, j + k, 0)));
                vi = int'($signed(gen(pat, seed, j + k, 1)));
                s  = bsym(sel, j);
                cr = (s == 0) ? 1 : (s == 2) ? -1 : 0;
                ci = (s == 1) ? 1 : (s == 3) ? -1 : 0;
                sr += cr * vr - ci * vi;
                si += cr * vi + ci * vr;
            end
            exp_re[k] = sr;
            exp_im[k] = si;
        end
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_total++;
        if (ok) n_pass++;
        else $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    endtask

    task automatic check_bins(input string req);
        bit ok;
        int bad_b, a_v, e_v;
        ok = 1'b1; bad_b = 0; a_v = 0; e_v = 0;
        for (int b = 0; b < 16; b++) begin
            rd_bin = 4'(b);
            #1;
            if (ok && (int'($signed(rd_re)) != exp_re[b] || int'($signed(rd_im)) != exp_im[b])) begin
                ok = 1'b0; bad_b = b;
                a_v = (int'($signed(rd_re)) != exp_re[b]) ? int'($signed(rd_re)) : int'($signed(rd_im));
                e_v = (int'($signed(rd_re)) != exp_re[b]) ? exp_re[b] : exp_im[b];
            end
        end
        chk(ok, req, $sformatf("bin %0d value", bad_b), a_v, e_v);
    endtask

    task automatic set_code(input int v);
        @(negedge clk); sel_in = 4'(v); sel_we = 1'b1;
        @(negedge clk); sel_we = 1'b0;
    endtask

    task automatic run_window(input int pat, input int seed, input int nsamp, input int mid_sel);
        @(negedge clk); win_n = 1'b0; smp_stb = 1'b0;
        for (int n = 0; n < nsamp; n++) begin
            @(negedge clk); smp_stb = 1'b1;
            adc_i = gen(pat, seed, n, 0); adc_q = gen(pat, seed, n, 1);
            @(negedge clk); smp_stb = 1'b0; adc_i = 10'h2AA; adc_q = 10'h155;
            if (mid_sel != 0 && n == 5) begin
                sel_in = 4'(mid_sel); sel_we = 1'b1;
                @(negedge clk); sel_we = 1'b0;
            end
        end
        @(negedge clk); win_n = 1'b1;
    endtask

    task automatic wait_done(input int maxc, output int pulses, output bit wide);
        bit prev;
        prev = 1'b0; pulses = 0; wide = 1'b0;
        for (int c = 0; c < maxc; c++) begin
            @(negedge clk);
            if (done) begin
                pulses++;
                if (prev) wide = 1'b1;
            end
            prev = done;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_total++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

    initial begin
        int pulses;
        bit wide;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        chk(done == 1'b0, "R10", "done after reset", done, 0);
        for (int k = 0; k < 16; k++) begin exp_re[k] = 0; exp_im[k] = 0; end
        check_bins("R10 results zero after reset");

        // R10: select 1 active without any write
        compute_expected(1, 2, 17);
        run_window(2, 17, 17, 0);
        wait_done(700, pulses, wide);
        chk(pulses == 1, "R10", "done count default code", pulses, 1);
        check_bins("R10 default code 1");

        // R1 R3 R4 R7: table walk over all codes and patterns
        for (int v = 0; v < 11; v++) begin
            int sel, pat, seed;
            sel  = int'(VEC[v][11:8]);
            pat  = int'(VEC[v][7:6]);
            seed = int'(VEC[v][5:0]);
            set_code(sel);
            compute_expected(sel, pat, seed);
            run_window(pat, seed, blen(sel) + 16, 0);
            wait_done(700, pulses, wide);
            chk(pulses == 1 && !wide, "R7", $sformatf("done pulse vec %0d", v), pulses, 1);
            check_bins($sformatf("R1 R3 R4 vec %0d", v));
        end

        // R7: results held after done
        repeat (50) @(negedge clk);
        check_bins("R7 results held");

        // R6: illegal selects ignored
        set_code(4);
        set_code(0);
        set_code(12);
        compute_expected(4, 2, 5);
        run_window(2, 5, 23, 0);
        wait_done(700, pulses, wide);
        chk(pulses == 1, "R6", "done count", pulses, 1);
        check_bins("R6 code 4 kept");

        // R5: write during window does not affect it, applies to next
        set_code(3);
        compute_expected(3, 2, 33);
        run_window(2, 33, 21, 9);
        wait_done(700, pulses, wide);
        chk(pulses == 1, "R5", "done count mid write", pulses, 1);
        check_bins("R5 window kept code 3");
        compute_expected(9, 3, 0);
        run_window(3, 0, 47, 0);
        wait_done(700, pulses, wide);
        chk(pulses == 1, "R5", "done count next window", pulses, 1);
        check_bins("R5 next window uses code 9");

        // R2: strobes outside window and surplus samples ignored
        set_code(5);
        for (int n = 0; n < 3; n++) begin
            @(negedge clk); smp_stb = 1'b1; adc_i = 10'h123; adc_q = 10'h321;
            @(negedge clk); smp_stb = 1'b0;
        end
        compute_expected(5, 2, 40);
        run_window(2, 40, 32, 0);
        wait_done(700, pulses, wide);
        chk(pulses == 1, "R2", "done count surplus", pulses, 1);
        check_bins("R2 stray and surplus samples");

        // R8: short window yields nothing, results unchanged
        run_window(1, 0, 26, 0);
        wait_done(800, pulses, wide);
        chk(pulses == 0, "R8", "done count short window", pulses, 0);
        check_bins("R8 results unchanged");

        // R9: window opened during computation ignored
        set_code(9);
        compute_expected(9, 2, 30);
        run_window(2, 30, 47, 0);
        run_window(1, 0, 47, 0);
        wait_done(1200, pulses, wide);
        chk(pulses == 1, "R9", "done count overlap", pulses, 1);
        check_bins("R9 first window results");

        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

endmodule